// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

The block decides when a chip-level reset output goes active and when it may drop again. It watches five kinds of reset cause: a debounced external reset pin, a software request, a clock-loss fault, a PLL-unlock fault, and a power-on or low-voltage event. Each cause enters a shared release path. That path waits for the external pin to go high, then for PLL lock, then for a fixed settle count. It then captures the configuration pins and releases the reset.

Pin and software requests are polite. They first enable the bus monitor and keep the reset output low until the bus cycle in flight reports done. Clock and lock faults are abrupt: they drive the reset output at once. A new cause that appears while a sequence is running sends the sequencer back to the proper earlier step. A power-on event always starts the whole sequence again. A one-hot status word records which cause last started a reset.

Top module: `rst_seq_ctrl`

## Requirements
- R1: The pin request `ext_rst_n` is honoured only after it is sampled low on at least FILT_LEN (default 4) consecutive rising edges. Any high sample restarts that count, so a shorter low pulse leaves every output unchanged.
- R2: A software request or an honoured pin request, taken while idle, raises `busmon_en` with `rst_out` low. `rst_out` rises one cycle after `bus_done` is sampled high, and `busmon_en` drops in that same cycle.
- R3: After `rst_out` rises, the sequencer holds `rst_out` high while `ext_rst_n` is sampled low. Only after it is sampled high does it move on to the lock wait.
- R4: In the lock wait, a high `pll_lock` starts a settle count. The count lasts CNT_LEN (default 512) cycles, with the counter at 0 on entry and finishing when it reads CNT_LEN-1.
- R5: When the count finishes, `cfg_latch` is high for exactly one cycle with `rst_out` still high, and `cfg_val` takes the `cfg_pins` value sampled on the final count edge. `rst_out` falls in the next cycle.
- R6: `loss_clk` or `loss_lock` sampled high while idle raises `rst_out` in the next cycle without any bus-cycle wait, and the sequence continues with the lock wait.
- R7: `loss_lock` sampled high during the settle count returns the sequencer to the lock wait, and a later lock restarts the full count. This also holds in the cycle where the count would have finished.
- R8: An honoured pin request during the lock wait or the settle count returns the sequencer to waiting for `ext_rst_n` to go high.
- R9: `por_req` high on any edge forces `rst_out` high and sets the status to power-on, whatever the state. After `por_req` goes low, the sequence continues with the lock wait.
- R10: `loss_clk` or `loss_lock` during the bus-cycle wait ends that wait. `rst_out` rises next cycle, the status records the pending pin or software cause, and the sequencer then waits for `ext_rst_n` to go high.
- R11: `status` is one-hot with bit 0 power-on, bit 1 pin, bit 2 software, bit 3 clock loss and bit 4 lock loss. It changes only in the cycle `rst_out` rises or on power-on, and it keeps its value after release.
- R12: When several causes arrive together while idle, the priority is clock loss, then lock loss, then pin, then software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on / low-voltage restart, active high, synchronous |
| ext_rst_n | input | 1 | External reset pin, active low |
| sw_req | input | 1 | Software reset request |
| loss_clk | input | 1 | Clock-loss fault |
| loss_lock | input | 1 | PLL lock-loss fault |
| bus_done | input | 1 | Current bus cycle has completed |
| pll_lock | input | 1 | PLL locked |
| cfg_pins | input | CFG_W | Configuration pin levels |
| rst_out | output | 1 | Reset output, active high |
| busmon_en | output | 1 | Bus-monitor enable during the bus-cycle wait |
| cfg_latch | output | 1 | One-cycle configuration capture strobe |
| status | output | 5 | One-hot cause of the last reset |
| cfg_val | output | CFG_W | Captured configuration |

## Verification
Two collisions are forced on purpose. First, `loss_lock` is pulsed on the exact cycle in which the settle counter reads its last value. Here the fault must win: `cfg_latch` stays low and the count starts again from zero. Second, a fault arrives together with `bus_done` during the bus wait. Both paths lead to the pin wait, and the status must name the pending request, not the fault. The bench places both events using its own model of the count, and every cycle it compares the outputs with that model.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int NSRC   = 5;
    localparam int SB_POR = 0;
    localparam int SB_EXT = 1;
    localparam int SB_SW  = 2;
    localparam int SB_LOC = 3;
    localparam int SB_LOL = 4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BUSW  = 3'd1,
        ST_EXTW  = 3'd2,
        ST_LOCKW = 3'd3,
        ST_COUNT = 3'd4,
        ST_CFG   = 3'd5,
        ST_POR   = 3'd6
    } rsc_state_e;

    function automatic logic [NSRC-1:0] src_bit(input int idx);
        logic [NSRC-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/rsc_pin_filter.sv
module rsc_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic pin_n,
    output logic valid
);
    localparam int FW = $clog2(FILT_LEN + 1);
    localparam logic [FW-1:0] FMAX = FW'(FILT_LEN);

    logic [FW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || pin_n) begin
            cnt_d = '0;
        end else if (cnt_q != FMAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign valid = (cnt_q == FMAX);
endmodule

// File: rtl/rsc_rel_counter.sv
module rsc_rel_counter #(
    parameter int CNT_LEN = 512
) (
    input  logic clk,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = $clog2(CNT_LEN) + 1;
    localparam logic [CW-1:0] LAST = CW'(CNT_LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign done = en && (cnt_q == LAST);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rsc_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int CNT_LEN  = 512,
    parameter int CFG_W    = 4
) (
    input  logic             clk,
    input  logic             por_req,
    input  logic             ext_rst_n,
    input  logic             sw_req,
    input  logic             loss_clk,
    input  logic             loss_lock,
    input  logic             bus_done,
    input  logic             pll_lock,
    input  logic [CFG_W-1:0] cfg_pins,
    output logic             rst_out,
    output logic             busmon_en,
    output logic             cfg_latch,
    output logic [NSRC-1:0]  status,
    output logic [CFG_W-1:0] cfg_val
);
    typedef struct packed {
        rsc_state_e       state;
        logic [NSRC-1:0]  status;
        logic             pend_ext;
        logic [CFG_W-1:0] cfg;
    } regs_t;

    regs_t r_d, r_q;
    logic  ext_valid;
    logic  cnt_done;

    rsc_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .clr   (por_req),
        .pin_n (ext_rst_n),
        .valid (ext_valid)
    );

    rsc_rel_counter #(.CNT_LEN(CNT_LEN)) u_cnt (
        .clk  (clk),
        .clr  (por_req || (r_q.state != ST_COUNT)),
        .en   (r_q.state == ST_COUNT),
        .done (cnt_done)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_POR: begin
                r_d.state = ST_LOCKW;
            end
            ST_IDLE: begin
                if (loss_clk) begin
                    r_d.state  = ST_LOCKW;
                    r_d.status = src_bit(SB_LOC);
                end else if (loss_lock) begin
                    r_d.state  = ST_LOCKW;
                    r_d.status = src_bit(SB_LOL);
                end else if (ext_valid) begin
                    r_d.state    = ST_BUSW;
                    r_d.pend_ext = 1'b1;
                end else if (sw_req) begin
                    r_d.state    = ST_BUSW;
                    r_d.pend_ext = 1'b0;
                end
            end
            ST_BUSW: begin
                if (bus_done || loss_clk || loss_lock) begin
                    r_d.state  = ST_EXTW;
                    r_d.status = r_q.pend_ext ? src_bit(SB_EXT) : src_bit(SB_SW);
                end
            end
            ST_EXTW: begin
                if (ext_rst_n) begin
                    r_d.state = ST_LOCKW;
                end
            end
            ST_LOCKW: begin
                if (ext_valid) begin
                    r_d.state = ST_EXTW;
                end else if (pll_lock) begin
                    r_d.state = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (ext_valid) begin
                    r_d.state = ST_EXTW;
                end else if (loss_lock) begin
                    r_d.state = ST_LOCKW;
                end else if (cnt_done) begin
                    r_d.state = ST_CFG;
                    r_d.cfg   = cfg_pins;
                end
            end
            ST_CFG: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_POR;
            end
        endcase
        if (por_req) begin
            r_d.state    = ST_POR;
            r_d.status   = src_bit(SB_POR);
            r_d.pend_ext = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign rst_out   = (r_q.state != ST_IDLE) && (r_q.state != ST_BUSW);
    assign busmon_en = (r_q.state == ST_BUSW);
    assign cfg_latch = (r_q.state == ST_CFG);
    assign status    = r_q.status;
    assign cfg_val   = r_q.cfg;
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
    parameter int FILT_LEN = 4,
    parameter int NS       = 5
) (
    input logic          clk,
    input logic          por_req,
    input logic          ext_rst_n,
    input logic          bus_done,
    input logic          loss_clk,
    input logic          loss_lock,
    input logic          rst_out,
    input logic          busmon_en,
    input logic          cfg_latch,
    input logic [NS-1:0] status,
    input logic          ext_valid
);
    int low_cnt;

    always_ff @(posedge clk) begin
        if (por_req || ext_rst_n) low_cnt <= 0;
        else if (low_cnt < FILT_LEN) low_cnt <= low_cnt + 1;
    end

    AST_EXT_FILTERED: assert property (@(posedge clk) disable iff (por_req)
        ext_valid |-> low_cnt >= FILT_LEN); // R1
    AST_BUSMON_QUIET: assert property (@(posedge clk) disable iff (por_req)
        busmon_en |-> !rst_out); // R2
    AST_BUS_BEFORE_RST: assert property (@(posedge clk) disable iff (por_req)
        ($rose(rst_out) && $past(busmon_en)) |-> $past(bus_done || loss_clk || loss_lock)); // R2
    AST_RELEASE_AFTER_LATCH: assert property (@(posedge clk) disable iff (por_req)
        $fell(rst_out) |-> $past(cfg_latch)); // R5
    AST_LATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (por_req)
        cfg_latch |=> (!cfg_latch && !rst_out)); // R5
    AST_FAULT_IMMEDIATE: assert property (@(posedge clk) disable iff (por_req)
        (!rst_out && !busmon_en && (loss_clk || loss_lock)) |=> rst_out); // R6
    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (por_req)
        $countones(status) == 1); // R11
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (por_req)
        (rst_out && $past(rst_out) && !$past(por_req)) |-> $stable(status)); // R11
endmodule

bind rst_seq_ctrl rsc_checker #(.FILT_LEN(FILT_LEN), .NS(rsc_pkg::NSRC)) u_chk (
    .clk       (clk),
    .por_req   (por_req),
    .ext_rst_n (ext_rst_n),
    .bus_done  (bus_done),
    .loss_clk  (loss_clk),
    .loss_lock (loss_lock),
    .rst_out   (rst_out),
    .busmon_en (busmon_en),
    .cfg_latch (cfg_latch),
    .status    (status),
    .ext_valid (ext_valid)
);

// File: tb/tb_rst_seq_ctrl.sv
module tb_rst_seq_ctrl;
    localparam int P_IDLE = 0, P_BUSW = 1, P_EXTW = 2, P_LOCKW = 3,
                   P_COUNT = 4, P_CFG = 5, P_POR = 6;

    logic       clk = 1'b0;
    logic       por_req = 1'b1, ext_rst_n = 1'b1, sw_req = 1'b0;
    logic       loss_clk = 1'b0, loss_lock = 1'b0, bus_done = 1'b0, pll_lock = 1'b0;
    logic [3:0] cfg_pins = 4'h5;
    logic       rst_out, busmon_en, cfg_latch;
    logic [4:0] status;
    logic [3:0] cfg_val;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    bit    finished = 0;
    string cur_req = "R9";

    int         m_ph = P_POR, m_low = 0, m_cnt = 0, m_pext = 0;
    logic [4:0] m_stat = 5'b00001;
    logic [3:0] m_cfg = 4'h0;

    always #2 clk = ~clk;

    rst_seq_ctrl dut (
        .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n), .sw_req(sw_req),
        .loss_clk(loss_clk), .loss_lock(loss_lock), .bus_done(bus_done),
        .pll_lock(pll_lock), .cfg_pins(cfg_pins), .rst_out(rst_out),
        .busmon_en(busmon_en), .cfg_latch(cfg_latch), .status(status),
        .cfg_val(cfg_val)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        bit v, done;
        int nph;
        v    = (m_low >= 4);
        done = (m_ph == P_COUNT) && (m_cnt == 511);
        m_cnt = (m_ph == P_COUNT && !por_req) ? m_cnt + 1 : 0;
        m_low = (por_req || ext_rst_n) ? 0 : (m_low < 4 ? m_low + 1 : 4);
        nph = m_ph;
        if (por_req) begin
            nph = P_POR; m_stat = 5'b00001; m_pext = 0;
        end else if (m_ph == P_POR) nph = P_LOCKW;
        else if (m_ph == P_IDLE) begin
            if (loss_clk)       begin nph = P_LOCKW; m_stat = 5'b01000; end
            else if (loss_lock) begin nph = P_LOCKW; m_stat = 5'b10000; end
            else if (v)         begin nph = P_BUSW;  m_pext = 1; end
            else if (sw_req)    begin nph = P_BUSW;  m_pext = 0; end
        end else if (m_ph == P_BUSW) begin
            if (bus_done || loss_clk || loss_lock) begin
                nph = P_EXTW; m_stat = m_pext ? 5'b00010 : 5'b00100;
            end
        end else if (m_ph == P_EXTW) begin
            if (ext_rst_n) nph = P_LOCKW;
        end else if (m_ph == P_LOCKW) begin
            if (v) nph = P_EXTW; else if (pll_lock) nph = P_COUNT;
        end else if (m_ph == P_COUNT) begin
            if (v) nph = P_EXTW;
            else if (loss_lock) nph = P_LOCKW;
            else if (done) begin nph = P_CFG; m_cfg = cfg_pins; end
        end else if (m_ph == P_CFG) nph = P_IDLE;
        m_ph = nph;
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        logic [15:0] a, e;
        if (cyc > 0) begin
            a = {4'h0, rst_out, busmon_en, cfg_latch, status, cfg_val};
            e = {4'h0, !(m_ph == P_IDLE || m_ph == P_BUSW), m_ph == P_BUSW,
                 m_ph == P_CFG, m_stat, m_cfg};
            check(cur_req, a, e);
        end
    end

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wait_ph(int p);
        while (m_ph != p) @(negedge clk);
    endtask
    task automatic pulse_lol();
        loss_lock = 1; step(1); loss_lock = 0;
    endtask

    initial begin
        // R9: power-on, then lock wait, count, release
        step(3); por_req = 0;
        cur_req = "R4"; step(6); pll_lock = 1;
        wait_ph(P_CFG); cur_req = "R5";
        wait_ph(P_IDLE); step(1);
        check("R5", cfg_val, 4'h5);
        check("R9", status, 5'b00001);

        // R2: software request waits for bus completion
        cur_req = "R2"; cfg_pins = 4'hA;
        sw_req = 1; step(1); sw_req = 0; step(4);
        check("R2", {rst_out, busmon_en}, 2'b01);
        bus_done = 1; step(1); bus_done = 0;
        check("R2", {rst_out, busmon_en}, 2'b10);
        wait_ph(P_IDLE); step(1);
        check("R11", status, 5'b00100);
        check("R5", cfg_val, 4'hA);

        // R1: a 3-cycle low pulse is ignored; a long one is honoured
        cur_req = "R1";
        ext_rst_n = 0; step(3); ext_rst_n = 1; step(4);
        check("R1", {rst_out, busmon_en}, 2'b00);
        ext_rst_n = 0; step(8);
        check("R1", busmon_en, 1'b1);
        bus_done = 1; step(1); bus_done = 0;
        cur_req = "R3"; step(20);
        check("R3", rst_out, 1'b1);
        ext_rst_n = 1;
        wait_ph(P_IDLE); step(1);
        check("R11", status, 5'b00010);

        // R6: clock loss while idle
        cur_req = "R6";
        loss_clk = 1; step(1); loss_clk = 0;
        check("R6", {rst_out, busmon_en}, 2'b10);
        wait_ph(P_COUNT); cur_req = "R7"; step(100);
        pulse_lol();
        wait_ph(P_IDLE); step(1);
        check("R11", status, 5'b01000);

        // R7: lock loss collides with the last count cycle
        pulse_lol(); wait_ph(P_COUNT);
        while (!(m_ph == P_COUNT && m_cnt == 511)) @(negedge clk);
        pulse_lol();
        check("R7", {rst_out, cfg_latch}, 2'b10);
        wait_ph(P_IDLE);

        // R8: pin request during count and during lock wait
        cur_req = "R8";
        loss_clk = 1; step(1); loss_clk = 0;
        wait_ph(P_COUNT); step(50);
        ext_rst_n = 0; step(10);
        check("R8", rst_out, 1'b1);
        ext_rst_n = 1; wait_ph(P_IDLE);
        pll_lock = 0;
        loss_clk = 1; step(1); loss_clk = 0; step(3);
        ext_rst_n = 0; step(6); ext_rst_n = 1; step(2);
        pll_lock = 1; wait_ph(P_IDLE);

        // R10: fault ends the bus wait; also fault together with bus_done
        cur_req = "R10";
        sw_req = 1; step(1); sw_req = 0; step(2);
        loss_lock = 1; step(1); loss_lock = 0;
        check("R10", {rst_out, busmon_en}, 2'b10);
        wait_ph(P_IDLE); step(1);
        check("R10", status, 5'b00100);
        ext_rst_n = 0; step(6);
        loss_clk = 1; bus_done = 1; step(1); loss_clk = 0; bus_done = 0;
        step(10); ext_rst_n = 1;
        wait_ph(P_IDLE); step(1);
        check("R10", status, 5'b00010);

        // R9: power-on in the middle of a count
        cur_req = "R9";
        loss_clk = 1; step(1); loss_clk = 0;
        wait_ph(P_COUNT); step(30);
        por_req = 1; step(2); por_req = 0;
        check("R9", {rst_out, status}, 6'b100001);
        wait_ph(P_IDLE);

        // R12: simultaneous causes while idle
        cur_req = "R12";
        loss_clk = 1; loss_lock = 1; sw_req = 1; step(1);
        loss_clk = 0; loss_lock = 0; sw_req = 0;
        check("R12", {rst_out, status}, 6'b101000);
        wait_ph(P_IDLE); step(2);
        summary();
    end
endmodule